// File: doc/BRIEF.md
# TLB Invalidate-All Sequencer

This block holds a small first-stage translation table and a second-stage table of the same shape. Each table has a fixed number of entries. Every entry carries a valid flag, a non-secure tag, the exception-level regime that owns it, a virtual machine identifier and a host-regime flag. The block serves invalidate-all requests. It visits every entry of the first-stage table in turn and clears each one that matches. When the request calls for it, the block then hands a derived request to the second-stage table and waits for that table to finish.

Two kinds of request are supported. A target-regime request clears the entries that belong to a named exception level, and it forwards to the second stage when that level is EL1. A current-regime request uses the same matching rule, but it forwards only when it was issued from EL2. In both cases the virtual machine identifier of an entry plays no part in the match.

Each stage counts the requests it has taken and the entries it has cleared. A fill port and a probe port allow a table to be loaded and inspected; apart from that, lookup and refill are not part of the block.

Top module: `tlb_inval_all`

## Requirements
- R1: A request is taken only when `req_ready` is 1. `req_ready` is 0 while `busy` is 1, and a request presented while busy leaves every entry and every counter unchanged.
- R2: The first-stage walk checks one entry per clock, in index order from 0 to ENTRIES-1. For a request that is not forwarded, `done` goes high exactly ENTRIES cycles after the clock edge at which the request is taken.
- R3: A walk clears an entry only when all of the following hold: the entry is valid, its non-secure tag is the inverse of `req_secure`, and its stored level equals the request level. For level EL2, the entry's host flag must also equal the request's host mode. Levels are encoded 1=EL1, 2=EL2, 3=EL3. The virtual machine identifier is never compared, and it is kept unchanged.
- R4: The host mode of a request is 1 only when `req_tge` and `req_e2h` are both 1.
- R5: A target-regime request (`req_op`=0) forwards to the second stage only when the level is EL1. The forwarded request targets EL1 with host mode 0 and carries the original `req_secure`. The second stage never forwards further.
- R6: A current-regime request (`req_op`=1) forwards only when it was issued at EL2. At EL1 it clears first-stage entries only.
- R7: For each stage, the flushed-entries count rises by one for each entry cleared, and the request count rises by one for each request taken.
- R8: `done` is a one-cycle pulse, and `busy` falls in the same cycle. When a request is forwarded, `done` comes only after the second stage has finished, which is 2*ENTRIES+2 cycles after the request is taken.
- R9: A fill (`fill_en`=1) writes a valid entry at `fill_idx` of the stage chosen by `fill_stage2`. A fill is ignored while `busy` is 1.
- R10: After reset, all entries are invalid, all counters are zero, `busy` and `done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = target-regime, 1 = current-regime |
| req_el | input | 2 | Target or issuing level (1..3) |
| req_secure | input | 1 | Secure-lookup flag |
| req_tge | input | 1 | Trap-general-exceptions control bit |
| req_e2h | input | 1 | Hypervisor-host control bit |
| busy | output | 1 | Request in progress, including any second-stage work |
| done | output | 1 | One-cycle completion pulse |
| fill_en | input | 1 | Write one entry |
| fill_stage2 | input | 1 | Fill selects the second-stage table |
| fill_idx | input | clog2(ENTRIES) | Entry index for the fill |
| fill_ns | input | 1 | Non-secure tag of the filled entry |
| fill_el | input | 2 | Owning level of the filled entry |
| fill_vmid | input | VMID_W | Virtual machine identifier of the filled entry |
| fill_host | input | 1 | Host-regime flag of the filled entry |
| probe_idx | input | clog2(ENTRIES) | Index to inspect |
| s1_probe_valid | output | 1 | Valid flag of the first-stage entry at the probe index |
| s1_probe_vmid | output | VMID_W | Identifier of the first-stage entry at the probe index |
| s2_probe_valid | output | 1 | Valid flag of the second-stage entry at the probe index |
| s2_probe_vmid | output | VMID_W | Identifier of the second-stage entry at the probe index |
| s1_flushed | output | CNT_W | First-stage cleared-entry count |
| s1_flushes | output | CNT_W | First-stage request count |
| s2_flushed | output | CNT_W | Second-stage cleared-entry count |
| s2_flushes | output | CNT_W | Second-stage request count |

## Verification
The assertions assume that `req_el` lies in 1..3 whenever a request is presented, and that fills are not issued for indices outside the table. The bench always drives legal levels and in-range indices. Each table-driven request starts from a freshly reloaded pattern, so no vector depends on what an earlier one cleared. The bench makes its interfering request and its interfering fill only while `busy` is high, because those are the cases the refusal checks cover.

// File: rtl/tlb_inval_walker.sv
module tlb_inval_walker #(
  parameter int ENTRIES   = 8,
  parameter int VMID_W    = 8,
  parameter int CNT_W     = 16,
  parameter bit IS_STAGE2 = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_op,
  input  logic [1:0]                 req_el,
  input  logic                       req_secure,
  input  logic                       req_host,
  output logic                       fwd_valid,
  input  logic                       fwd_ready,
  output logic                       fwd_secure,
  input  logic                       fwd_done,
  input  logic                       fill_en,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic                       fill_ns,
  input  logic [1:0]                 fill_el,
  input  logic [VMID_W-1:0]          fill_vmid,
  input  logic                       fill_host,
  input  logic [$clog2(ENTRIES)-1:0] probe_idx,
  output logic                       probe_valid,
  output logic [VMID_W-1:0]          probe_vmid,
  output logic                       busy,
  output logic                       done,
  output logic [CNT_W-1:0]           flushed_cnt,
  output logic [CNT_W-1:0]           flush_cnt
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  typedef enum logic [1:0] {IDLE, WALK, FWD, WAIT} st_t;
  st_t st;

  logic              ent_v    [ENTRIES];
  logic              ent_ns   [ENTRIES];
  logic [1:0]        ent_el   [ENTRIES];
  logic [VMID_W-1:0] ent_vmid [ENTRIES];
  logic              ent_host [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic             r_op, r_sec, r_host;
  logic [1:0]       r_el;

  wire fill_ok  = fill_en && (st == IDLE);
  wire hit      = ent_v[idx] && (ent_ns[idx] == !r_sec) && (ent_el[idx] == r_el)
                  && (r_el != 2'd2 || ent_host[idx] == r_host);
  wire need_fwd = !IS_STAGE2 && (r_op ? (r_el == 2'd2) : (r_el == 2'd1));

  assign req_ready   = (st == IDLE);
  assign busy        = (st != IDLE);
  assign fwd_valid   = (st == FWD);
  assign fwd_secure  = r_sec;
  assign probe_valid = ent_v[probe_idx];
  assign probe_vmid  = ent_vmid[probe_idx];

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      ent_ns[fill_idx]   <= fill_ns;
      ent_el[fill_idx]   <= fill_el;
      ent_vmid[fill_idx] <= fill_vmid;
      ent_host[fill_idx] <= fill_host;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      idx         <= '0;
      r_op        <= 1'b0;
      r_el        <= 2'd0;
      r_sec       <= 1'b0;
      r_host      <= 1'b0;
      done        <= 1'b0;
      flushed_cnt <= '0;
      flush_cnt   <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fill_ok) ent_v[fill_idx] <= 1'b1;
      case (st)
        IDLE: if (req_valid) begin
          r_op      <= req_op;
          r_el      <= req_el;
          r_sec     <= req_secure;
          r_host    <= req_host;
          idx       <= '0;
          flush_cnt <= flush_cnt + 1'b1;
          st        <= WALK;
        end
        WALK: begin
          if (hit) begin
            ent_v[idx]  <= 1'b0;
            flushed_cnt <= flushed_cnt + 1'b1;
          end
          if (idx == LAST) begin
            if (need_fwd) st <= FWD;
            else begin
              st   <= IDLE;
              done <= 1'b1;
            end
          end else idx <= idx + 1'b1;
        end
        FWD:  if (fwd_ready) st <= WAIT;
        WAIT: if (fwd_done) begin
          st   <= IDLE;
          done <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> flush_cnt == $past(flush_cnt)); // R1
  AST_NO_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(flushed_cnt)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_secure)); // R5
endmodule

// File: rtl/tlb_inval_all.sv
module tlb_inval_all #(
  parameter int ENTRIES = 8,
  parameter int VMID_W  = 8,
  parameter int CNT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_op,
  input  logic [1:0]                 req_el,
  input  logic                       req_secure,
  input  logic                       req_tge,
  input  logic                       req_e2h,
  output logic                       busy,
  output logic                       done,
  input  logic                       fill_en,
  input  logic                       fill_stage2,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic                       fill_ns,
  input  logic [1:0]                 fill_el,
  input  logic [VMID_W-1:0]          fill_vmid,
  input  logic                       fill_host,
  input  logic [$clog2(ENTRIES)-1:0] probe_idx,
  output logic                       s1_probe_valid,
  output logic [VMID_W-1:0]          s1_probe_vmid,
  output logic                       s2_probe_valid,
  output logic [VMID_W-1:0]          s2_probe_vmid,
  output logic [CNT_W-1:0]           s1_flushed,
  output logic [CNT_W-1:0]           s1_flushes,
  output logic [CNT_W-1:0]           s2_flushed,
  output logic [CNT_W-1:0]           s2_flushes
);
  logic fwd_valid, fwd_ready, fwd_secure, s2_done;
  logic s2_fwd_valid, s2_fwd_secure, s2_busy;

  tlb_inval_walker #(.ENTRIES(ENTRIES), .VMID_W(VMID_W), .CNT_W(CNT_W), .IS_STAGE2(1'b0)) u_s1 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_el(req_el),
    .req_secure(req_secure), .req_host(req_tge && req_e2h),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_secure(fwd_secure), .fwd_done(s2_done),
    .fill_en(fill_en && !fill_stage2), .fill_idx(fill_idx), .fill_ns(fill_ns), .fill_el(fill_el),
    .fill_vmid(fill_vmid), .fill_host(fill_host),
    .probe_idx(probe_idx), .probe_valid(s1_probe_valid), .probe_vmid(s1_probe_vmid),
    .busy(busy), .done(done), .flushed_cnt(s1_flushed), .flush_cnt(s1_flushes));

  tlb_inval_walker #(.ENTRIES(ENTRIES), .VMID_W(VMID_W), .CNT_W(CNT_W), .IS_STAGE2(1'b1)) u_s2 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(fwd_valid), .req_ready(fwd_ready), .req_op(1'b0), .req_el(2'd1),
    .req_secure(fwd_secure), .req_host(1'b0),
    .fwd_valid(s2_fwd_valid), .fwd_ready(1'b0), .fwd_secure(s2_fwd_secure), .fwd_done(1'b0),
    .fill_en(fill_en && fill_stage2), .fill_idx(fill_idx), .fill_ns(fill_ns), .fill_el(fill_el),
    .fill_vmid(fill_vmid), .fill_host(fill_host),
    .probe_idx(probe_idx), .probe_valid(s2_probe_valid), .probe_vmid(s2_probe_vmid),
    .busy(s2_busy), .done(s2_done), .flushed_cnt(s2_flushed), .flush_cnt(s2_flushes));

  AST_S2_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_fwd_valid); // R5
  AST_S2_KEEPS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    s2_busy |-> s2_fwd_secure == fwd_secure); // R5
  AST_S2_INSIDE_S1: assert property (@(posedge clk) disable iff (!rst_n)
    s2_busy |-> busy); // R8
endmodule

// File: tb/test_tlb_inval_all.sv
`timescale 1ns/1ps
module test_tlb_inval_all;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_op = 0, req_secure = 0, req_tge = 0, req_e2h = 0;
  logic [1:0] req_el = 2'd1;
  logic fill_en = 0, fill_stage2 = 0, fill_ns = 0, fill_host = 0;
  logic [2:0] fill_idx = 0, probe_idx = 0;
  logic [1:0] fill_el = 0;
  logic [VW-1:0] fill_vmid = 0;
  logic req_ready, busy, done, s1_probe_valid, s2_probe_valid;
  logic [VW-1:0] s1_probe_vmid, s2_probe_vmid;
  logic [CW-1:0] s1_flushed, s1_flushes, s2_flushed, s2_flushes;

  tlb_inval_all #(.ENTRIES(N), .VMID_W(VW), .CNT_W(CW)) i_tlb_inval_all (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_el(req_el), .req_secure(req_secure), .req_tge(req_tge), .req_e2h(req_e2h),
    .busy(busy), .done(done), .fill_en(fill_en), .fill_stage2(fill_stage2), .fill_idx(fill_idx),
    .fill_ns(fill_ns), .fill_el(fill_el), .fill_vmid(fill_vmid), .fill_host(fill_host),
    .probe_idx(probe_idx), .s1_probe_valid(s1_probe_valid), .s1_probe_vmid(s1_probe_vmid),
    .s2_probe_valid(s2_probe_valid), .s2_probe_vmid(s2_probe_vmid),
    .s1_flushed(s1_flushed), .s1_flushes(s1_flushes), .s2_flushed(s2_flushed), .s2_flushes(s2_flushes));

  typedef struct packed {
    logic op; logic [1:0] el; logic sec; logic tge; logic e2h;
    logic [3:0] n1; logic [3:0] n2; logic fwd;
  } vec_t;
  localparam vec_t VEC [9] = '{
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 4'd1, 4'd4, 1'b1},
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd2, 4'd4, 1'b1},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 4'd1, 4'd0, 1'b0},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 4'd1, 4'd0, 1'b0},
    '{1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 4'd1, 4'd0, 1'b0},
    '{1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0, 1'b0},
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 4'd1, 4'd0, 1'b0},
    '{1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 4'd1, 4'd4, 1'b1},
    '{1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0}
  };

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic m_v [2][N];
  logic m_ns [2][N];
  logic [1:0] m_el [2][N];
  logic m_host [2][N];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input bit s2, input int i, input bit ns, input logic [1:0] el,
                      input logic [VW-1:0] vm, input bit h);
    fill_en = 1; fill_stage2 = s2; fill_idx = 3'(i); fill_ns = ns; fill_el = el;
    fill_vmid = vm; fill_host = h;
    @(posedge clk); @(negedge clk);
    fill_en = 0;
  endtask

  task automatic load_pattern();
    bit ns1 [N] = '{0, 1, 0, 0, 1, 0, 1, 1};
    logic [1:0] el1 [N] = '{1, 1, 2, 2, 2, 3, 1, 2};
    bit h1 [N] = '{0, 0, 1, 0, 1, 0, 0, 0};
    logic [VW-1:0] vm1 [N] = '{3, 5, 0, 0, 7, 0, 1, 2};
    for (int i = 0; i < N; i++) begin
      fill(0, i, ns1[i], el1[i], vm1[i], h1[i]);
      m_v[0][i] = 1; m_ns[0][i] = ns1[i]; m_el[0][i] = el1[i]; m_host[0][i] = h1[i];
      fill(1, i, i[0], 2'd1, VW'(i), 0);
      m_v[1][i] = 1; m_ns[1][i] = i[0]; m_el[1][i] = 2'd1; m_host[1][i] = 0;
    end
  endtask

  // R3 matching rule written from the requirement
  function automatic void model_clear(input int s, input logic [1:0] el, input bit sec, input bit host);
    for (int i = 0; i < N; i++)
      if (m_v[s][i] && m_ns[s][i] == !sec && m_el[s][i] == el && (el != 2'd2 || m_host[s][i] == host))
        m_v[s][i] = 0;
  endfunction

  task automatic compare_masks(input string tag);
    logic [N-1:0] a1, a2, e1, e2;
    for (int i = 0; i < N; i++) begin
      probe_idx = 3'(i); #1;
      a1[i] = s1_probe_valid; a2[i] = s2_probe_valid;
      e1[i] = m_v[0][i]; e2[i] = m_v[1][i];
    end
    check(a1 == e1, {tag, " stage1 valid mask"}, a1, e1);
    check(a2 == e2, {tag, " stage2 valid mask"}, a2, e2);
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [CW-1:0] f1, f2, c1, c2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R10 reset state
    check(req_ready == 1, "R10 req_ready", req_ready, 1);
    check(busy == 0, "R10 busy", busy, 0);
    check(done == 0, "R10 done", done, 0);
    check(s1_flushed == 0 && s1_flushes == 0, "R10 stage1 counters", s1_flushed + s1_flushes, 0);
    check(s2_flushed == 0 && s2_flushes == 0, "R10 stage2 counters", s2_flushed + s2_flushes, 0);
    for (int i = 0; i < N; i++) begin m_v[0][i] = 0; m_v[1][i] = 0; end
    compare_masks("R10");

    // table-driven requests: R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 9; v++) begin
      load_pattern();
      // R9 fills land while idle
      compare_masks("R9 after load");
      f1 = s1_flushed; c1 = s1_flushes; f2 = s2_flushed; c2 = s2_flushes;
      req_valid = 1; req_op = VEC[v].op; req_el = VEC[v].el; req_secure = VEC[v].sec;
      req_tge = VEC[v].tge; req_e2h = VEC[v].e2h;
      @(posedge clk); @(negedge clk);
      req_valid = 0;
      wait_done(lat);
      model_clear(0, VEC[v].el, VEC[v].sec, VEC[v].tge & VEC[v].e2h);
      if (VEC[v].fwd) model_clear(1, 2'd1, VEC[v].sec, 1'b0);
      check(lat == (VEC[v].fwd ? 2*N+2 : N), "R2/R8 latency", lat, VEC[v].fwd ? 2*N+2 : N);
      check(busy == 0, "R8 busy falls with done", busy, 0);
      check(s1_flushed - f1 == CW'(VEC[v].n1), "R3 R7 stage1 cleared", s1_flushed - f1, VEC[v].n1);
      check(s2_flushed - f2 == CW'(VEC[v].n2), "R5 R6 stage2 cleared", s2_flushed - f2, VEC[v].n2);
      check(s1_flushes - c1 == 1, "R7 stage1 requests", s1_flushes - c1, 1);
      check(s2_flushes - c2 == CW'(VEC[v].fwd), "R5 R6 forward count", s2_flushes - c2, VEC[v].fwd);
      compare_masks("R3 R4");
      @(posedge clk); @(negedge clk);
      check(done == 0, "R8 done one cycle", done, 0);
    end

    // R1 and R9: refused request and ignored fill while busy
    load_pattern();
    f1 = s1_flushed; c1 = s1_flushes; f2 = s2_flushed; c2 = s2_flushes;
    req_valid = 1; req_op = 0; req_el = 2'd3; req_secure = 0; req_tge = 0; req_e2h = 0;
    @(posedge clk); @(negedge clk);
    check(req_ready == 0, "R1 not ready while busy", req_ready, 0);
    req_el = 2'd1; req_secure = 1;
    fill_en = 1; fill_stage2 = 0; fill_idx = 0; fill_ns = 1; fill_el = 2'd3; fill_vmid = 8'hAA; fill_host = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0; fill_en = 0;
    wait_done(lat);
    check(lat == N - 1, "R1 original request timing", lat, N - 1);
    check(s1_flushes - c1 == 1, "R1 stage1 request count", s1_flushes - c1, 1);
    check(s2_flushes - c2 == 0, "R1 no forward from refused", s2_flushes - c2, 0);
    check(s1_flushed - f1 == 0, "R1 nothing cleared", s1_flushed - f1, 0);
    compare_masks("R1");
    probe_idx = 0; #1;
    check(s1_probe_vmid == 8'd3, "R9 fill ignored while busy", s1_probe_vmid, 3);
    // R3 identifier kept on second stage
    probe_idx = 3'd5; #1;
    check(s2_probe_vmid == 8'd5, "R3 vmid retained", s2_probe_vmid, 5);

    // R4: EL2 with only tge set uses host 0
    @(negedge clk);
    f1 = s1_flushed;
    req_valid = 1; req_op = 0; req_el = 2'd2; req_secure = 0; req_tge = 1; req_e2h = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    wait_done(lat);
    model_clear(0, 2'd2, 1'b0, 1'b0);
    check(s1_flushed - f1 == 1, "R4 host mode needs both bits", s1_flushed - f1, 1);
    compare_masks("R4");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule